// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Engine

The engine raises a K-bit base to a K-bit exponent modulo an odd K-bit modulus. Every product it forms is a Montgomery product, A·B·2^(-K) mod M. These products come from a radix-2, bit-serial multiplier that keeps its accumulator as a carry-save pair. Each of its K steps therefore costs only two rows of full adders, with no carry ripple.

The caller presents the base X, the exponent E, the modulus M and the constant R2 = 2^(2K) mod M, then pulses `start`. The engine moves X into the Montgomery domain by multiplying it with R2. It forms the domain image of one as the product of R2 and 1. It then scans E from the top bit down, squaring the accumulator for every bit and multiplying it by the converted base for every set bit. A last product with 1 returns the result to the integer domain. When the result is ready, `done` pulses and `y` carries the result.

Top module: `mexp_engine`

## Requirements
- R1: For odd M and R2 = 2^(2K) mod M, the `y` presented with `done` equals X^E mod M.
- R2: An exponent of zero yields 1 mod M, which is 1 for M ≥ 3 and 0 for M = 1.
- R3: `done` is low from reset onward and is never high in two consecutive cycles.
- R4: `y` is zero after reset and changes only in a cycle where `done` is high. Between completions it keeps its value.
- R5: The engine captures X, E, M and R2 in the cycle in which it accepts `start`. While a computation runs, a further `start` and any change on the operand inputs have no effect on the result or on its timing.
- R6: A base X greater than or equal to M is accepted and gives the same result as X mod M.
- R7: Every result presented with `done` is smaller than M.
- R8: If the engine accepts `start` at clock edge 0, `done` is high right after edge (K+3)·(K+3+w), where w is the number of ones in E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a computation; honoured only when idle |
| x | input | K | Base |
| e | input | K | Exponent |
| m | input | K | Odd modulus |
| r2 | input | K | 2^(2K) mod M, reduced below M |
| y | output | K | Result X^E mod M |
| done | output | 1 | One-cycle completion pulse |

## Verification
A fault in the carry-save accumulator or in the parity choice of the multiplier corrupts the first Montgomery product. Every later product inherits the error, so a wrong `y` shows up at the very next `done`. Broad sweeps over the modulus therefore expose it quickly.

A fault in the exponent scanner, such as a skipped bit or a missing square, affects `y` only for exponents with particular bit patterns. The same fault also moves `done` away from its exact cycle, since the number of products depends on the number of ones in E. The bench checks that cycle as well as the value.

Leaks from the operand inputs during a run show up as a wrong result for the originally captured operands. Disturbed runs make these leaks visible.

// File: rtl/mexp_pkg.sv
package mexp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER_X,
        ST_ENTER_ONE,
        ST_SQUARE,
        ST_MULTIPLY,
        ST_LEAVE
    } seq_state_e;

    // Extra accumulator headroom: the carry-save sum stays below 4*M before a shift.
    localparam int unsigned ACC_GUARD = 2;

endpackage

// File: rtl/mexp_montmul.sv
module mexp_montmul
    import mexp_pkg::*;
#(
    parameter int unsigned K = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [K-1:0] a,
    input  logic [K-1:0] b,
    input  logic [K-1:0] m,
    output logic [K-1:0] p,
    output logic         done
);
    localparam int unsigned W  = K + ACC_GUARD;
    localparam int unsigned CW = $clog2(K + 1);

    logic [K-1:0]  a_sh, b_q;
    logic [W-1:0]  s_q, c_q;
    logic [CW-1:0] step;
    logic          run;

    logic [W-1:0] addend_b, addend_m;
    logic [W-1:0] s1, c1, s2, c2;
    logic [W-1:0] total, reduced;
    logic         odd;

    always_comb begin
        addend_b = a_sh[0] ? {{ACC_GUARD{1'b0}}, b_q} : '0;
        // first carry-save row: fold in a_i * B
        s1  = s_q ^ c_q ^ addend_b;
        c1  = ((s_q & c_q) | (s_q & addend_b) | (c_q & addend_b)) << 1;
        odd = s1[0];
        addend_m = odd ? {{ACC_GUARD{1'b0}}, m} : '0;
        // second row: make the sum even by adding M
        s2  = s1 ^ c1 ^ addend_m;
        c2  = ((s1 & c1) | (s1 & addend_m) | (c1 & addend_m)) << 1;
        // final resolution of the redundant pair
        total   = s_q + c_q;
        reduced = (total >= {{ACC_GUARD{1'b0}}, m}) ? total - {{ACC_GUARD{1'b0}}, m} : total;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_sh <= '0;
            b_q  <= '0;
            s_q  <= '0;
            c_q  <= '0;
            step <= '0;
            run  <= 1'b0;
            p    <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!run) begin
                if (go) begin
                    a_sh <= a;
                    b_q  <= b;
                    s_q  <= '0;
                    c_q  <= '0;
                    step <= '0;
                    run  <= 1'b1;
                end
            end else if (step == CW'(K)) begin
                p    <= reduced[K-1:0];
                done <= 1'b1;
                run  <= 1'b0;
            end else begin
                s_q  <= s2 >> 1;
                c_q  <= c2 >> 1;
                a_sh <= a_sh >> 1;
                step <= step + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mexp_seq.sv
module mexp_seq
    import mexp_pkg::*;
#(
    parameter int unsigned K = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [K-1:0] x,
    input  logic [K-1:0] e,
    input  logic [K-1:0] m,
    input  logic [K-1:0] r2,
    input  logic         mm_done,
    input  logic [K-1:0] mm_p,
    output logic         mm_go,
    output logic [K-1:0] mm_a,
    output logic [K-1:0] mm_b,
    output logic [K-1:0] m_q,
    output logic         busy,
    output logic [K-1:0] y,
    output logic         done
);
    localparam int unsigned IW = (K > 1) ? $clog2(K) : 1;
    localparam logic [K-1:0] ONE = K'(1);

    seq_state_e    state;
    logic [K-1:0]  x_q, e_q, r2_q, acc, base;
    logic [IW-1:0] idx;

    always_comb begin
        unique case (state)
            ST_ENTER_X:   begin mm_a = x_q;  mm_b = r2_q; end
            ST_ENTER_ONE: begin mm_a = r2_q; mm_b = ONE;  end
            ST_SQUARE:    begin mm_a = acc;  mm_b = acc;  end
            ST_MULTIPLY:  begin mm_a = acc;  mm_b = base; end
            ST_LEAVE:     begin mm_a = acc;  mm_b = ONE;  end
            default:      begin mm_a = '0;   mm_b = '0;   end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            x_q   <= '0;
            e_q   <= '0;
            m_q   <= '0;
            r2_q  <= '0;
            acc   <= '0;
            base  <= '0;
            idx   <= '0;
            mm_go <= 1'b0;
            busy  <= 1'b0;
            y     <= '0;
            done  <= 1'b0;
        end else begin
            mm_go <= 1'b0;
            done  <= 1'b0;
            if (state == ST_IDLE) begin
                if (start) begin
                    x_q   <= x;
                    e_q   <= e;
                    m_q   <= m;
                    r2_q  <= r2;
                    state <= ST_ENTER_X;
                    mm_go <= 1'b1;
                    busy  <= 1'b1;
                end
            end else if (mm_done) begin
                unique case (state)
                    ST_ENTER_X: begin
                        base  <= mm_p;
                        state <= ST_ENTER_ONE;
                        mm_go <= 1'b1;
                    end
                    ST_ENTER_ONE: begin
                        acc   <= mm_p;
                        idx   <= IW'(K - 1);
                        state <= ST_SQUARE;
                        mm_go <= 1'b1;
                    end
                    ST_SQUARE: begin
                        acc   <= mm_p;
                        mm_go <= 1'b1;
                        if (e_q[idx]) begin
                            state <= ST_MULTIPLY;
                        end else if (idx == '0) begin
                            state <= ST_LEAVE;
                        end else begin
                            idx <= idx - 1'b1;
                        end
                    end
                    ST_MULTIPLY: begin
                        acc   <= mm_p;
                        mm_go <= 1'b1;
                        if (idx == '0) begin
                            state <= ST_LEAVE;
                        end else begin
                            idx   <= idx - 1'b1;
                            state <= ST_SQUARE;
                        end
                    end
                    ST_LEAVE: begin
                        y     <= mm_p;
                        done  <= 1'b1;
                        busy  <= 1'b0;
                        state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/mexp_engine.sv
module mexp_engine
    import mexp_pkg::*;
#(
    parameter int unsigned K = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [K-1:0] x,
    input  logic [K-1:0] e,
    input  logic [K-1:0] m,
    input  logic [K-1:0] r2,
    output logic [K-1:0] y,
    output logic         done
);
    logic         mm_go, mm_done, seq_busy;
    logic [K-1:0] mm_a, mm_b, mm_p, m_q;

    mexp_seq #(.K(K)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .x       (x),
        .e       (e),
        .m       (m),
        .r2      (r2),
        .mm_done (mm_done),
        .mm_p    (mm_p),
        .mm_go   (mm_go),
        .mm_a    (mm_a),
        .mm_b    (mm_b),
        .m_q     (m_q),
        .busy    (seq_busy),
        .y       (y),
        .done    (done)
    );

    mexp_montmul #(.K(K)) u_mul (
        .clk  (clk),
        .rst  (rst),
        .go   (mm_go),
        .a    (mm_a),
        .b    (mm_b),
        .m    (m_q),
        .p    (mm_p),
        .done (mm_done)
    );

endmodule

// File: rtl/mexp_checker.sv
module mexp_checker #(
    parameter int unsigned K = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         done,
    input logic         busy,
    input logic [K-1:0] y,
    input logic [K-1:0] m_q
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                      // R3

    AST_Y_HELD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(y));                                // R4

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));                                // R3

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done) && $stable(m_q));  // R5

    AST_RESULT_REDUCED: assert property (@(posedge clk) disable iff (rst)
        (done && m_q[0]) |-> (y < m_q));                      // R7
endmodule

bind mexp_engine mexp_checker #(.K(K)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .done  (done),
    .busy  (seq_busy),
    .y     (y),
    .m_q   (m_q)
);

// File: tb/mexp_engine_test.sv
module mexp_engine_test;
    localparam int unsigned K = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [K-1:0] x = '0, e = '0, m = '0, r2 = '0;
    logic [K-1:0] y;
    logic         done;

    int checks = 0;
    int failures = 0;
    int total_cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mexp_engine #(.K(K)) uut (
        .clk(clk), .rst(rst), .start(start),
        .x(x), .e(e), .m(m), .r2(r2),
        .y(y), .done(done)
    );

    function automatic longint ref_pow(longint bx, longint ex, longint md);
        longint r = 1 % md;
        longint b = bx % md;
        for (int i = 0; i < K; i++) begin
            if (ex[i]) r = (r * b) % md;
            b = (b * b) % md;
        end
        return r;
    endfunction

    function automatic int ones(longint v);
        int c = 0;
        for (int i = 0; i < K; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic run(int xi, int ei, int mi, bit disturb, bit hold);
        int cyc;
        longint expv;
        int lat;
        logic [K-1:0] ykeep;
        @(negedge clk);
        x = K'(xi); e = K'(ei); m = K'(mi);
        r2 = K'((longint'(1) << (2 * K)) % mi);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        if (disturb) begin
            x = ~x; e = ~e; m = m ^ 8'h42; r2 = ~r2;
        end
        while (!done && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            start = (disturb && cyc == 40);
        end
        start = 1'b0;
        expv = ref_pow(xi, ei, mi);
        lat  = (K + 3) * (K + 3 + ones(ei));
        // R1 / R2 / R6 / R5: value captured at start
        check(done && (longint'(y) == expv), (ei == 0) ? "R2" : (xi >= mi ? "R6" : (disturb ? "R5" : "R1")),
              longint'(y), expv);
        check(cyc == lat + 1, "R8", cyc - 1, lat);
        check(y < K'(mi) || !done, "R7", longint'(y), mi);
        ykeep = y;
        @(negedge clk);
        check(!done, "R3", done, 0);
        if (hold) begin
            repeat (5) @(negedge clk);
            x = ~x; e = ~e;
            @(negedge clk);
            check(y == ykeep && !done, "R4", longint'(y), longint'(ykeep));
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            total_cycles++;
            if (total_cycles > 190000 && !finished) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", total_cycles, 190000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        int seed = 12345;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R3 / R4: reset state
        check(done == 1'b0, "R3", done, 0);
        check(y == '0, "R4", longint'(y), 0);

        for (int mm = 1; mm < 256; mm += 2) begin
            int xa, ea;
            seed = seed * 1103515245 + 12345;
            xa = (seed >>> 8) & 255;
            ea = (seed >>> 16) & 255;
            run(xa % mm, ea, mm, (mm % 8) == 1, (mm % 16) == 3);
            run(255, 255, mm, 1'b0, 1'b0);
            run(xa, 0, mm, 1'b0, 1'b0);           // R2 zero exponent
            run(mm + ((xa % (256 - mm + 1 > 0 ? 256 - mm : 1))) , (ea | 1), mm, 1'b0, 1'b0); // R6 large base
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule